// File: doc/BRIEF.md
# SPI Serial Clock and Chip-Select Delay Timer

This block is the timing core of an SPI master. It reads the prescaler and scaler codes from a 32-bit clock-and-transfer attributes word and turns them into three counts in system clocks: the serial clock half-periods, the setup delay from chip-select assertion to the first clock edge, and the hold delay from the last clock edge to chip-select release.

When the controller pulses a start request with a bit count, the block runs one frame through five phases: idle, lead delay, clocking, trail delay and done. It drives the serial clock and a chip-select-active window. It gives the data path one-cycle sample and shift strobes on the matching clock edges, and ends the frame with a one-cycle done pulse. The shift register and the FIFOs sit outside this block.

Top module: `spi_sck_timing_gen`

## Requirements
- R1: The SCK period in system clocks is the baud prescaler value times the baud scaler value. The baud prescaler code in attr bits 17:16 maps 0,1,2,3 to 2,3,5,7. The baud scaler code in attr bits 3:0 maps codes 0 to 3 to 2,4,6,8, and each code c from 4 to 15 to 2^c.
- R2: A computed period below the parameter SCK_MIN_DIV is raised to SCK_MIN_DIV, which caps the SCK rate at the system clock divided by that factor.
- R3: Within the clocking phase, every half-period with SCK high lasts floor(period/2) clocks. Every half-period with SCK low lasts the rest of the period.
- R4: The lead delay (chip-select active, SCK at rest, before clocking) lasts p×2^(s+1) clocks. Here p is {1,3,5,7} selected by attr bits 23:22, and s is attr bits 15:12.
- R5: The trail delay (after clocking, SCK at rest, chip-select still active) lasts p×2^(s+1) clocks, with p selected by attr bits 21:20 and s taken from attr bits 11:8.
- R6: SCK sits at the polarity level, attr bit 26, while idle, during both delays and in the done cycle. Across one frame of n bits it changes level exactly 2n times.
- R7: With the phase bit (attr bit 25) at 0, the first SCK edge comes one half-period after the lead delay ends. With it at 1, the first edge comes right as the lead delay ends, and the last half-period runs at the rest level before the trail delay.
- R8: sample_o pulses for one cycle on each of the n sampling edges: the edge away from rest when the phase bit is 0, and the edge toward rest when it is 1. shift_o pulses on the other edges, except the first edge when the phase bit is 0 and the final return to rest. The two strobes never coincide.
- R9: done_o pulses for exactly one cycle, in the cycle right after the trail delay ends. busy_o and cs_active_o are both low in the next cycle.
- R10: A start request that arrives while a frame is running is ignored. It neither changes that frame nor queues a new one.
- R11: A bit count of 0 runs a one-bit frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| attr_i | input | 32 | Clock-and-transfer attributes word; captured at frame start |
| start_i | input | 1 | Start-of-frame request, sampled while idle |
| nbits_i | input | NB_W (5) | Number of bits in the frame |
| sck_o | output | 1 | Serial clock |
| cs_active_o | output | 1 | High from lead delay through trail delay |
| sample_o | output | 1 | Strobe for the data path to sample MISO |
| shift_o | output | 1 | Strobe for the data path to advance MOSI |
| busy_o | output | 1 | Frame in progress, done cycle included |
| done_o | output | 1 | One-cycle end-of-frame pulse |

## Verification
The bound checker watches several properties on every cycle. done_o never lasts longer than one cycle. The fall of the chip-select window always lands on a done cycle. Each strobe falls on a real SCK edge inside the window, and the two strobes never coincide. Once busy, the block stays busy until done. The exact durations are shown only by the bench's sweeps over prescaler, scaler, mode and bit-count combinations: the period arithmetic and clamp, the high and low split, the lead and trail delays, and where the first and last edges fall for each phase setting.

// File: rtl/spi_tg_pkg.sv
package spi_tg_pkg;

  localparam int unsigned PER_W = 18;  // 7 * 32768 fits
  localparam int unsigned DLY_W = 19;  // 7 * 65536 fits

  localparam int unsigned CPOL_BIT  = 26;
  localparam int unsigned CPHA_BIT  = 25;
  localparam int unsigned LEAD_P_LO = 22;
  localparam int unsigned TRL_P_LO  = 20;
  localparam int unsigned BAUD_P_LO = 16;
  localparam int unsigned LEAD_S_LO = 12;
  localparam int unsigned TRL_S_LO  = 8;
  localparam int unsigned BAUD_S_LO = 0;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_CLK,
    ST_TRAIL,
    ST_DONE
  } tg_state_e;

  function automatic logic [PER_W-1:0] baud_period(logic [1:0] pc, logic [3:0] sc);
    logic [PER_W-1:0] pre;
    logic [PER_W-1:0] scl;
    case (pc)
      2'd0:    pre = PER_W'(2);
      2'd1:    pre = PER_W'(3);
      2'd2:    pre = PER_W'(5);
      default: pre = PER_W'(7);
    endcase
    if (sc < 4'd4) scl = PER_W'((32'(sc) + 1) * 2);
    else           scl = PER_W'(1) << sc;
    return PER_W'(pre * scl);
  endfunction

  function automatic logic [DLY_W-1:0] delay_count(logic [1:0] pc, logic [3:0] sc);
    logic [DLY_W-1:0] pre;
    pre = DLY_W'({pc, 1'b1});  // 1,3,5,7
    return pre << (32'(sc) + 1);
  endfunction

endpackage

// File: rtl/spi_tg_baud.sv
module spi_tg_baud
  import spi_tg_pkg::*;
#(
  parameter int unsigned SCK_MIN_DIV = 2
) (
  input  logic [1:0]       pre_i,
  input  logic [3:0]       scl_i,
  output logic [PER_W-1:0] hi_o,
  output logic [PER_W-1:0] lo_o
);

  localparam logic [PER_W-1:0] MinPer = PER_W'(SCK_MIN_DIV);

  logic [PER_W-1:0] raw_per;
  logic [PER_W-1:0] per;

  always_comb begin
    raw_per = baud_period(pre_i, scl_i);
    per     = (raw_per < MinPer) ? MinPer : raw_per;
    hi_o    = per >> 1;
    lo_o    = per - (per >> 1);
  end

endmodule

// File: rtl/spi_tg_delay.sv
module spi_tg_delay
  import spi_tg_pkg::*;
(
  input  logic [1:0]       pre_i,
  input  logic [3:0]       scl_i,
  output logic [DLY_W-1:0] cnt_o
);

  assign cnt_o = delay_count(pre_i, scl_i);

endmodule

// File: rtl/spi_tg_seq.sv
module spi_tg_seq
  import spi_tg_pkg::*;
#(
  parameter int unsigned MAX_BITS = 16,
  parameter int unsigned NB_W     = $clog2(MAX_BITS + 1),
  parameter int unsigned IDX_W    = $clog2(2 * MAX_BITS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [NB_W-1:0]  nbits_i,
  input  logic             cpol_i,
  input  logic             cpha_i,
  input  logic [PER_W-1:0] hi_i,
  input  logic [PER_W-1:0] lo_i,
  input  logic [DLY_W-1:0] lead_i,
  input  logic [DLY_W-1:0] trail_i,
  output logic             sck_o,
  output logic             cs_active_o,
  output logic             sample_o,
  output logic             shift_o,
  output logic             busy_o,
  output logic             done_o
);

  tg_state_e        state_q;
  logic [DLY_W-1:0] cnt_q;
  logic [IDX_W-1:0] idx_q, last_idx_q;
  logic             first_q;
  logic [PER_W-1:0] hi_q, lo_q;
  logic [DLY_W-1:0] trail_q;
  logic             cpol_q, cpha_q;

  logic             level_k;
  logic [PER_W-1:0] len_first, len_next;
  logic [NB_W-1:0]  nb_eff;

  always_comb begin
    level_k   = cpol_q ^ cpha_q ^ idx_q[0];
    len_first = (cpol_q ^ cpha_q) ? hi_q : lo_q;
    len_next  = level_k ? lo_q : hi_q;  // next half has the opposite level
    nb_eff    = (nbits_i == '0) ? NB_W'(1) : nbits_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      cnt_q      <= '0;
      idx_q      <= '0;
      last_idx_q <= '0;
      first_q    <= 1'b0;
      hi_q       <= '0;
      lo_q       <= '0;
      trail_q    <= '0;
      cpol_q     <= 1'b0;
      cpha_q     <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            state_q    <= ST_LEAD;
            cnt_q      <= lead_i - DLY_W'(1);
            hi_q       <= hi_i;
            lo_q       <= lo_i;
            trail_q    <= trail_i;
            cpol_q     <= cpol_i;
            cpha_q     <= cpha_i;
            last_idx_q <= IDX_W'(2 * int'(nb_eff) - 1);
          end
        end
        ST_LEAD: begin
          if (cnt_q == '0) begin
            state_q <= ST_CLK;
            idx_q   <= '0;
            cnt_q   <= DLY_W'(len_first) - DLY_W'(1);
            first_q <= 1'b1;
          end else begin
            cnt_q <= cnt_q - DLY_W'(1);
          end
        end
        ST_CLK: begin
          if (cnt_q == '0) begin
            if (idx_q == last_idx_q) begin
              state_q <= ST_TRAIL;
              cnt_q   <= trail_q - DLY_W'(1);
              first_q <= 1'b0;
            end else begin
              idx_q   <= idx_q + IDX_W'(1);
              cnt_q   <= DLY_W'(len_next) - DLY_W'(1);
              first_q <= 1'b1;
            end
          end else begin
            cnt_q   <= cnt_q - DLY_W'(1);
            first_q <= 1'b0;
          end
        end
        ST_TRAIL: begin
          if (cnt_q == '0) state_q <= ST_DONE;
          else             cnt_q   <= cnt_q - DLY_W'(1);
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    unique case (state_q)
      ST_IDLE: sck_o = cpol_i;
      ST_CLK:  sck_o = level_k;
      default: sck_o = cpol_q;
    endcase
    cs_active_o = (state_q == ST_LEAD) || (state_q == ST_CLK) || (state_q == ST_TRAIL);
    busy_o      = (state_q != ST_IDLE);
    done_o      = (state_q == ST_DONE);
    sample_o    = (state_q == ST_CLK) && first_q && idx_q[0];
    shift_o     = (state_q == ST_CLK) && first_q && !idx_q[0] && (cpha_q || (idx_q != '0));
  end

endmodule

// File: rtl/spi_sck_timing_gen.sv
module spi_sck_timing_gen
  import spi_tg_pkg::*;
#(
  parameter int unsigned MAX_BITS    = 16,
  parameter int unsigned SCK_MIN_DIV = 2,
  localparam int unsigned NB_W       = $clog2(MAX_BITS + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [31:0]     attr_i,
  input  logic            start_i,
  input  logic [NB_W-1:0] nbits_i,
  output logic            sck_o,
  output logic            cs_active_o,
  output logic            sample_o,
  output logic            shift_o,
  output logic            busy_o,
  output logic            done_o
);

  localparam int unsigned NumDly = 2;  // 0: lead, 1: trail

  logic [PER_W-1:0] hi_cnt, lo_cnt;
  logic [DLY_W-1:0] dly_cnt [NumDly];

  logic unused_attr;
  assign unused_attr = ^{attr_i[31:27], attr_i[24], attr_i[7:4]};

  spi_tg_baud #(
    .SCK_MIN_DIV(SCK_MIN_DIV)
  ) i_baud (
    .pre_i(attr_i[BAUD_P_LO +: 2]),
    .scl_i(attr_i[BAUD_S_LO +: 4]),
    .hi_o (hi_cnt),
    .lo_o (lo_cnt)
  );

  for (genvar g = 0; g < NumDly; g++) begin : g_dly
    localparam int unsigned PLo = (g == 0) ? LEAD_P_LO : TRL_P_LO;
    localparam int unsigned SLo = (g == 0) ? LEAD_S_LO : TRL_S_LO;
    spi_tg_delay i_dly (
      .pre_i(attr_i[PLo +: 2]),
      .scl_i(attr_i[SLo +: 4]),
      .cnt_o(dly_cnt[g])
    );
  end

  spi_tg_seq #(
    .MAX_BITS(MAX_BITS)
  ) i_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .nbits_i    (nbits_i),
    .cpol_i     (attr_i[CPOL_BIT]),
    .cpha_i     (attr_i[CPHA_BIT]),
    .hi_i       (hi_cnt),
    .lo_i       (lo_cnt),
    .lead_i     (dly_cnt[0]),
    .trail_i    (dly_cnt[1]),
    .sck_o      (sck_o),
    .cs_active_o(cs_active_o),
    .sample_o   (sample_o),
    .shift_o    (shift_o),
    .busy_o     (busy_o),
    .done_o     (done_o)
  );

endmodule

// File: rtl/spi_tg_checker.sv
module spi_tg_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic sck_o,
  input logic cs_active_o,
  input logic sample_o,
  input logic shift_o,
  input logic busy_o,
  input logic done_o
);

  assert_done_single_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_cs_end_done_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_active_o) |-> done_o);

  assert_strobe_excl_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sample_o && shift_o));

  assert_sample_edge_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_o |-> (sck_o != $past(sck_o)));

  assert_shift_edge_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_o |-> (sck_o != $past(sck_o)));

  assert_strobe_in_frame_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_o || shift_o) |-> cs_active_o);

  assert_busy_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o) |=> busy_o);

endmodule

bind spi_sck_timing_gen spi_tg_checker i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .sck_o      (sck_o),
  .cs_active_o(cs_active_o),
  .sample_o   (sample_o),
  .shift_o    (shift_o),
  .busy_o     (busy_o),
  .done_o     (done_o)
);

// File: tb/test_spi_sck_timing_gen.sv
module test_spi_sck_timing_gen;

  localparam int MAX_BITS = 16;
  localparam int MIN_DIV  = 8;
  localparam int NB_W     = $clog2(MAX_BITS + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [31:0]     attr = '0;
  logic            start = 1'b0;
  logic [NB_W-1:0] nbits = '0;
  logic sck_o, cs_active_o, sample_o, shift_o, busy_o, done_o;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  spi_sck_timing_gen #(
    .MAX_BITS(MAX_BITS),
    .SCK_MIN_DIV(MIN_DIV)
  ) i_spi_sck_timing_gen (
    .clk_i(clk), .rst_ni(rst_n), .attr_i(attr), .start_i(start), .nbits_i(nbits),
    .sck_o(sck_o), .cs_active_o(cs_active_o), .sample_o(sample_o),
    .shift_o(shift_o), .busy_o(busy_o), .done_o(done_o)
  );

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int baud_raw(int pc, int sc);
    int pre;
    int scl;
    pre = (pc == 0) ? 2 : (pc == 1) ? 3 : (pc == 2) ? 5 : 7;
    scl = (sc < 4) ? 2 * (sc + 1) : (1 << sc);
    return pre * scl;
  endfunction

  function automatic int dly(int pc, int sc);
    return (2 * pc + 1) * (1 << (sc + 1));
  endfunction

  function automatic logic [31:0] mk_attr(logic cpol, logic cpha, int bp, int bs,
                                          int lp, int ls, int tp, int ts);
    logic [31:0] a;
    a = '0;
    a[26] = cpol;
    a[25] = cpha;
    a[23:22] = 2'(lp);
    a[21:20] = 2'(tp);
    a[17:16] = 2'(bp);
    a[15:12] = 4'(ls);
    a[11:8]  = 4'(ts);
    a[3:0]   = 4'(bs);
    return a;
  endfunction

  task automatic run_frame(input logic cpol, input logic cpha, input int bp, input int bs,
                           input int lp, input int ls, input int tp, input int ts,
                           input int nb, input bit poke);
    int n, raw, per, hi, lo, lead, trail, rest_len;
    int c, ntog, first_tog, last_tog, run_err, str_err, nsam, nshf;
    logic prev, tog;
    logic [31:0] a;
    string preq;
    n     = (nb == 0) ? 1 : nb;
    raw   = baud_raw(bp, bs);
    per   = (raw < MIN_DIV) ? MIN_DIV : raw;
    hi    = per / 2;
    lo    = per - hi;
    lead  = dly(lp, ls);
    trail = dly(tp, ts);
    rest_len = cpol ? hi : lo;
    preq  = (raw < MIN_DIV) ? "R2" : "R1";
    a = mk_attr(cpol, cpha, bp, bs, lp, ls, tp, ts);
    c = 0; ntog = 0; first_tog = -1; last_tog = 0; run_err = 0; str_err = 0; nsam = 0; nshf = 0;
    @(negedge clk);
    attr = a; nbits = NB_W'(nb); start = 1'b1;
    prev = cpol;
    @(negedge clk);
    start = 1'b0;
    while (cs_active_o && c < 100000) begin
      if (poke && c == 1) begin
        start = 1'b1;
        attr = mk_attr(~cpol, ~cpha, 3, 6, 3, 5, 3, 5);
      end else if (poke && c == 2) begin
        start = 1'b0;
        attr = a;
      end
      tog = (sck_o !== prev);
      if (tog) begin
        if (ntog == 0) first_tog = c;
        else if (c - last_tog != (prev ? hi : lo)) run_err++;
        ntog++;
        last_tog = c;
      end
      if (sample_o) begin
        nsam++;
        if (!tog || sck_o !== (cpol ^ ~cpha)) str_err++;
      end
      if (shift_o) begin
        nshf++;
        if (!tog || sck_o !== (cpol ^ cpha)) str_err++;
      end
      prev = sck_o;
      c++;
      @(negedge clk);
    end
    chk(preq, "frame length", c, lead + n * per + trail);
    chk((nb == 0) ? "R11" : "R6", "sck toggles", ntog, 2 * n);
    chk("R4/R7", "first edge offset", first_tog, lead + (cpha ? 0 : rest_len));
    chk("R5/R7", "last edge to cs release", c - last_tog, trail + (cpha ? rest_len : 0));
    chk("R3", "half-period length errors", run_err, 0);
    chk("R8", "sample strobes", nsam, n);
    chk("R8", "shift strobes", nshf, cpha ? n : n - 1);
    chk("R8", "strobe edge errors", str_err, 0);
    chk("R9", "done in cycle after trail", done_o, 1);
    chk("R6", "sck at rest in done cycle", sck_o, cpol);
    @(negedge clk);
    chk("R9", "done single cycle", done_o, 0);
    chk("R9", "busy released", busy_o, 0);
    if (poke) begin
      c = 0;
      repeat (6) begin
        if (cs_active_o || busy_o) c++;
        @(negedge clk);
      end
      chk("R10", "no frame queued by mid-frame start", c, 0);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    attr = mk_attr(1'b1, 1'b0, 0, 0, 0, 0, 0, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9", "reset busy", busy_o, 0);
    chk("R9", "reset done", done_o, 0);
    chk("R6", "reset cs window", cs_active_o, 0);
    chk("R6", "idle sck follows polarity", sck_o, 1);
    chk("R8", "reset strobes", sample_o | shift_o, 0);

    // baud sweep over all modes
    for (int bp = 0; bp < 4; bp++)
      for (int bs = 0; bs < 5; bs++)
        for (int m = 0; m < 4; m++) begin
          run_frame(m[1], m[0], bp, bs, 0, 0, 0, 0, 1, 1'b0);
          run_frame(m[1], m[0], bp, bs, 0, 0, 0, 0, 3, 1'b0);
        end

    // delay sweep, lead and trail codes crossed
    for (int p = 0; p < 4; p++)
      for (int s = 0; s < 4; s++)
        run_frame(p[0], p[1], 0, 1, p, s, 3 - p, 3 - s, 2, 1'b0);

    run_frame(1'b0, 1'b1, 1, 0, 1, 1, 2, 0, 4, 1'b1);
    run_frame(1'b1, 1'b0, 0, 0, 0, 1, 0, 1, 0, 1'b0);
    run_frame(1'b0, 1'b0, 0, 0, 0, 0, 0, 0, MAX_BITS, 1'b0);
    run_frame(1'b1, 1'b1, 2, 1, 0, 0, 1, 0, MAX_BITS, 1'b0);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule